// File: doc/BRIEF.md
# Scheduled Cyclic Prefix Remover

This block sits at the front of an OFDM receiver, ahead of the FFT. It accepts a continuous stream of signed complex samples (16-bit real and imaginary parts) over a valid/ready interface. For every OFDM symbol it throws away a guard prefix of programmable length and then hands exactly N = 2^m samples to the output. The last of those samples carries an end-of-window flag. Dropped samples are still consumed from the input, so the upstream source never stalls on them.

The prefix length is not fixed. Symbol k takes its prefix length from entry k of a schedule table holding up to 2^L entries. The table is written through a simple write port. A second write port sets the window size exponent m, the index of the last loaded schedule entry, and a repeat flag. With repeat set, the schedule wraps back to entry 0 after the last loaded entry. With repeat clear, the schedule runs once, and every later symbol uses a prefix of zero. A symbol-restart input returns the schedule to entry 0 and the stream to a symbol boundary.

The sequencing is a three-state machine:
- ST_BOUND sits at a symbol boundary. The sample arriving there is judged against the live configuration.
- ST_DROP discards prefix samples.
- ST_PASS forwards window samples.

The transitions are named as follows:
- take-zero: from ST_BOUND to ST_PASS when the prefix is 0. The first sample is forwarded.
- take-one: from ST_BOUND to ST_PASS when the prefix is 1. That sample is dropped.
- take-long: from ST_BOUND to ST_DROP when the prefix is 2 or more.
- drop-done: from ST_DROP to ST_PASS on the final prefix sample.
- window-end: from ST_PASS to ST_BOUND on the N-th forwarded sample.
- restart: from any state to ST_BOUND.

Top module: `cp_sched_strip`

## Requirements
- R1: After reset the window exponent is 1 (N = 2), all schedule entries are 0, the last index is 0 and repeat is set; m_valid stays low while s_valid is low, and m_last is low.
- R2: For a symbol whose prefix length is cp, the first cp accepted samples are discarded: s_ready is 1 for them regardless of m_ready, and m_valid is 0.
- R3: After the prefix, exactly N accepted samples are forwarded unchanged (m_i = s_i, m_q = s_q), and m_last is 1 on the N-th of them only.
- R4: Symbol k after a restart uses schedule entry k (table index k) as its prefix length.
- R5: With repeat = 1, the symbol after the one using entry cfg_last uses entry 0 again.
- R6: With repeat = 0, once the symbol using entry cfg_last has started, every later symbol has prefix 0 until a restart.
- R7: N = 2^m where m comes from cfg_log2n, clamped to the range 1..MAX_LOG2 (0 becomes 1, values above MAX_LOG2 become MAX_LOG2).
- R8: Table writes and configuration writes are sampled only when the first sample of a symbol is accepted; a write during a symbol changes neither its prefix nor its window length.
- R9: While forwarding, s_ready equals m_ready and m_valid equals s_valid, so no sample is lost or duplicated under back-pressure.
- R10: A cycle with sym_rst = 1 puts the block at a symbol boundary, with the schedule back at entry 0 and a non-repeating list re-armed.
- R11: A schedule entry of 0 gives a window with no discarded samples, its first sample forwarded in the boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_rst | input | 1 | Restart symbol sequencing at schedule entry 0 |
| tab_we | input | 1 | Schedule table write strobe |
| tab_idx | input | L | Schedule entry to write |
| tab_cp | input | CPW | Prefix length written to that entry |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_log2n | input | MW | Window size exponent m |
| cfg_last | input | L | Index of the last loaded schedule entry |
| cfg_rep | input | 1 | 1: schedule wraps, 0: schedule runs once |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted |
| s_i | input | SW | Input real part, signed |
| s_q | input | SW | Input imaginary part, signed |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_i | output | SW | Output real part |
| m_q | output | SW | Output imaginary part |
| m_last | output | 1 | Last sample of the window |

## Verification
A wrong internal count or state shows at the ports within one sample. Forwarding in place of dropping appears at once as m_valid rising during a prefix. A miscounted window shows up as m_last arriving early or late, and the behavioural model catches that on that very sample. A wrong schedule pointer or a latched size taken at the wrong moment first shows at the next symbol boundary, as a wrong number of discarded samples. The model compares valid, ready, last and data every cycle, so the fault is flagged within one symbol.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    typedef enum logic [1:0] {
        ST_BOUND = 2'd0,
        ST_DROP  = 2'd1,
        ST_PASS  = 2'd2
    } cpr_state_t;
endpackage

// File: rtl/cpr_sched_table.sv
module cpr_sched_table #(
    parameter int L   = 5,
    parameter int CPW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [L-1:0]   waddr,
    input  logic [CPW-1:0] wdata,
    input  logic [L-1:0]   raddr,
    output logic [CPW-1:0] rdata
);
    localparam int DEPTH = 1 << L;

    logic [CPW-1:0] ent [DEPTH];

    // one register per schedule entry, each with its own write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (we && (waddr == L'(g))) begin
                ent[g] <= wdata;
            end
        end
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/cpr_sched_ptr.sv
module cpr_sched_ptr #(
    parameter int L = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    input  logic [L-1:0] last_idx,
    input  logic         rep,
    output logic [L-1:0] idx,
    output logic         over
);
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            idx  <= '0;
            over <= 1'b0;
        end else if (advance && !over) begin
            if (idx >= last_idx) begin
                if (rep) begin
                    idx <= '0;
                end else begin
                    over <= 1'b1;
                end
            end else begin
                idx <= idx + L'(1);
            end
        end
    end
endmodule

// File: rtl/cpr_window_fsm.sv
module cpr_window_fsm
    import cpr_pkg::*;
#(
    parameter int CPW  = 12,
    parameter int MW   = 4,
    parameter int CNTW = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            s_valid,
    input  logic            m_ready,
    input  logic [CPW-1:0]  cp_live,
    input  logic [MW-1:0]   log2n_live,
    output logic            fwd,
    output logic            acc_ready,
    output logic            take,
    output logic            last,
    output cpr_state_t      state,
    output logic [CNTW-1:0] cnt,
    output logic [MW-1:0]   cur_log2n
);
    cpr_state_t      nxt_state;
    logic [CNTW-1:0] nxt_cnt;
    logic [CPW-1:0]  cur_cp;
    logic [CPW-1:0]  nxt_cp;
    logic [MW-1:0]   nxt_log2n;
    logic [CNTW-1:0] nm1;
    logic [CNTW-1:0] cnt_inc;
    logic            hs;

    // outputs of the current state
    always_comb begin
        unique case (state)
            ST_BOUND: fwd = (cp_live == '0);
            ST_DROP:  fwd = 1'b0;
            ST_PASS:  fwd = 1'b1;
            default:  fwd = 1'b0;
        endcase
        nm1       = (CNTW'(1) << cur_log2n) - CNTW'(1);
        cnt_inc   = cnt + CNTW'(1);
        acc_ready = fwd ? m_ready : 1'b1;
        hs        = s_valid && acc_ready;
        take      = (state == ST_BOUND) && hs;
        last      = (state == ST_PASS) && (cnt == nm1);
    end

    // transitions
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_cp    = cur_cp;
        nxt_log2n = cur_log2n;
        if (restart) begin
            nxt_state = ST_BOUND;
            nxt_cnt   = '0;
        end else if (hs) begin
            unique case (state)
                ST_BOUND: begin
                    nxt_cp    = cp_live;
                    nxt_log2n = log2n_live;
                    if (cp_live == '0) begin
                        nxt_state = ST_PASS;          // take-zero
                        nxt_cnt   = CNTW'(1);
                    end else if (cp_live == CPW'(1)) begin
                        nxt_state = ST_PASS;          // take-one
                        nxt_cnt   = '0;
                    end else begin
                        nxt_state = ST_DROP;          // take-long
                        nxt_cnt   = CNTW'(1);
                    end
                end
                ST_DROP: begin
                    if (cnt_inc == CNTW'(cur_cp)) begin
                        nxt_state = ST_PASS;          // drop-done
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt   = cnt_inc;
                    end
                end
                ST_PASS: begin
                    if (last) begin
                        nxt_state = ST_BOUND;         // window-end
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt   = cnt_inc;
                    end
                end
                default: begin
                    nxt_state = ST_BOUND;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_BOUND;
            cnt       <= '0;
            cur_cp    <= '0;
            cur_log2n <= MW'(1);
        end else begin
            state     <= nxt_state;
            cnt       <= nxt_cnt;
            cur_cp    <= nxt_cp;
            cur_log2n <= nxt_log2n;
        end
    end
endmodule

// File: rtl/cp_sched_strip.sv
module cp_sched_strip
    import cpr_pkg::*;
#(
    parameter int SW      = 16,
    parameter int L       = 5,
    parameter int CPW     = 12,
    parameter int MAX_LOG2 = 10,
    parameter int MW      = $clog2(MAX_LOG2 + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sym_rst,
    input  logic           tab_we,
    input  logic [L-1:0]   tab_idx,
    input  logic [CPW-1:0] tab_cp,
    input  logic           cfg_we,
    input  logic [MW-1:0]  cfg_log2n,
    input  logic [L-1:0]   cfg_last,
    input  logic           cfg_rep,
    input  logic           s_valid,
    output logic           s_ready,
    input  logic [SW-1:0]  s_i,
    input  logic [SW-1:0]  s_q,
    output logic           m_valid,
    input  logic           m_ready,
    output logic [SW-1:0]  m_i,
    output logic [SW-1:0]  m_q,
    output logic           m_last
);
    localparam int CNTW = ((CPW > MAX_LOG2) ? CPW : MAX_LOG2) + 1;

    logic [MW-1:0]   reg_log2n;
    logic [L-1:0]    reg_last;
    logic            reg_rep;
    logic [MW-1:0]   log2n_clamped;
    logic [L-1:0]    sched_idx;
    logic            sched_over;
    logic [CPW-1:0]  tab_rdata;
    logic [CPW-1:0]  cp_live;
    logic            fwd;
    logic            acc_ready;
    logic            take;
    logic            win_last;
    cpr_state_t      state;
    logic [CNTW-1:0] cnt;
    logic [MW-1:0]   cur_log2n;

    always_comb begin
        if (cfg_log2n == '0) begin
            log2n_clamped = MW'(1);
        end else if (cfg_log2n > MW'(MAX_LOG2)) begin
            log2n_clamped = MW'(MAX_LOG2);
        end else begin
            log2n_clamped = cfg_log2n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_log2n <= MW'(1);
            reg_last  <= '0;
            reg_rep   <= 1'b1;
        end else if (cfg_we) begin
            reg_log2n <= log2n_clamped;
            reg_last  <= cfg_last;
            reg_rep   <= cfg_rep;
        end
    end

    cpr_sched_table #(.L(L), .CPW(CPW)) u_tab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tab_we),
        .waddr (tab_idx),
        .wdata (tab_cp),
        .raddr (sched_idx),
        .rdata (tab_rdata)
    );

    cpr_sched_ptr #(.L(L)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (sym_rst),
        .advance  (take),
        .last_idx (reg_last),
        .rep      (reg_rep),
        .idx      (sched_idx),
        .over     (sched_over)
    );

    assign cp_live = sched_over ? '0 : tab_rdata;

    cpr_window_fsm #(.CPW(CPW), .MW(MW), .CNTW(CNTW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (sym_rst),
        .s_valid    (s_valid),
        .m_ready    (m_ready),
        .cp_live    (cp_live),
        .log2n_live (reg_log2n),
        .fwd        (fwd),
        .acc_ready  (acc_ready),
        .take       (take),
        .last       (win_last),
        .state      (state),
        .cnt        (cnt),
        .cur_log2n  (cur_log2n)
    );

    assign s_ready = acc_ready;
    assign m_valid = s_valid && fwd;
    assign m_i     = s_i;
    assign m_q     = s_q;
    assign m_last  = win_last;
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker
    import cpr_pkg::*;
#(
    parameter int SW   = 16,
    parameter int MW   = 4,
    parameter int CNTW = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_valid,
    input logic            s_ready,
    input logic [SW-1:0]   s_i,
    input logic [SW-1:0]   s_q,
    input logic            m_valid,
    input logic            m_ready,
    input logic [SW-1:0]   m_i,
    input logic [SW-1:0]   m_q,
    input logic            m_last,
    input cpr_state_t      state,
    input logic [CNTW-1:0] cnt,
    input logic [MW-1:0]   cur_log2n
);
    logic [CNTW-1:0] win_size;
    assign win_size = CNTW'(1) << cur_log2n;

    a_r2_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> (s_ready && !m_valid));

    a_r9_fwd_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (s_valid && (s_ready == m_ready)));

    a_r3_data_intact: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ((m_i == s_i) && (m_q == s_q)));

    a_r3_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> (state == ST_BOUND));

    a_r3_last_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> (state == ST_PASS));

    a_r8_size_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_BOUND) && ($past(state) != ST_BOUND)) |-> $stable(cur_log2n));

    a_r7_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (cnt < win_size));
endmodule

bind cp_sched_strip cpr_checker #(.SW(SW), .MW(MW), .CNTW(CNTW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_i       (s_i),
    .s_q       (s_q),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_i       (m_i),
    .m_q       (m_q),
    .m_last    (m_last),
    .state     (state),
    .cnt       (cnt),
    .cur_log2n (cur_log2n)
);

// File: tb/cp_sched_strip_test.sv
module cp_sched_strip_test;
    localparam int SW = 16, L = 5, CPW = 12, MAXL = 10, MW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n = 1'b0, sym_rst = 1'b0;
    logic tab_we = 1'b0, cfg_we = 1'b0, cfg_rep = 1'b0;
    logic [L-1:0] tab_idx = '0, cfg_last = '0;
    logic [CPW-1:0] tab_cp = '0;
    logic [MW-1:0] cfg_log2n = '0;
    logic s_valid = 1'b0, m_ready = 1'b0;
    logic s_ready, m_valid, m_last;
    logic [SW-1:0] s_i = '0, s_q = '0, m_i, m_q;

    cp_sched_strip #(.SW(SW), .L(L), .CPW(CPW), .MAX_LOG2(MAXL), .MW(MW)) uut (.*);

    int checks = 0, fails = 0;
    // behavioural reference state
    int tab [32];
    int mdl_m = 1, mdl_lastidx = 0, mdl_idx = 0, mdl_drop = 0, mdl_pass = 0, mdl_n = 2;
    bit mdl_rep = 1, mdl_over = 0, mdl_bnd = 1;
    int fwd_run = 0;
    int dcnt = 0;

    function automatic int clampm(int v);
        if (v < 1) return 1;
        if (v > MAXL) return MAXL;
        return v;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare, update model after the edge
    task automatic step(string tag, int pv, int pr);
        bit sv, mr, ef, emv, esr, eml, hs;
        int cp_now;
        @(negedge clk);
        sv = ($urandom_range(99) < pv);
        mr = ($urandom_range(99) < pr);
        s_valid = sv; m_ready = mr;
        s_i = SW'(dcnt); s_q = SW'(~dcnt);
        #1;
        cp_now = mdl_over ? 0 : tab[mdl_idx];
        ef  = mdl_bnd ? (cp_now == 0) : (mdl_drop == 0);
        emv = sv && ef;
        esr = ef ? mr : 1'b1;
        eml = ef && !mdl_bnd && (mdl_pass == mdl_n - 1);
        chk({tag, "/R2"}, "m_valid", m_valid, emv);
        chk({tag, "/R9"}, "s_ready", s_ready, esr);
        chk({tag, "/R3"}, "m_last", m_last, eml);
        if (emv) chk({tag, "/R3"}, "m_i", m_i, s_i);
        if (m_valid && m_ready && m_last) chk({tag, "/R3"}, "window length", fwd_run + 1, mdl_n);
        hs = sv && esr;
        @(posedge clk);
        #1;
        if (hs) dcnt++;
        if (hs && ef) fwd_run = (eml ? 0 : fwd_run + 1);
        if (hs) begin
            if (mdl_bnd) begin
                if (!mdl_over) begin
                    if (mdl_idx >= mdl_lastidx) begin
                        if (mdl_rep) mdl_idx = 0; else mdl_over = 1;
                    end else mdl_idx++;
                end
                mdl_n = 1 << mdl_m;
                mdl_bnd = 0;
                if (cp_now == 0) begin mdl_pass = 1; mdl_drop = 0; end
                else begin mdl_pass = 0; mdl_drop = cp_now - 1; end
            end else if (mdl_drop > 0) begin
                mdl_drop--;
            end else begin
                mdl_pass++;
                if (mdl_pass == mdl_n) begin mdl_bnd = 1; mdl_pass = 0; end
            end
        end
        if (tab_we) tab[tab_idx] = int'(tab_cp);
        if (cfg_we) begin
            mdl_m = clampm(int'(cfg_log2n));
            mdl_lastidx = int'(cfg_last);
            mdl_rep = cfg_rep;
        end
        if (sym_rst) begin   // R10
            mdl_bnd = 1; mdl_idx = 0; mdl_over = 0; mdl_pass = 0; mdl_drop = 0; fwd_run = 0;
        end
    endtask

    task automatic wr_tab(int i, int v);
        tab_we = 1'b1; tab_idx = L'(i); tab_cp = CPW'(v);
        step("R8", 0, 100);
        tab_we = 1'b0;
    endtask

    task automatic wr_cfg(int m, int last, bit rep);
        cfg_we = 1'b1; cfg_log2n = MW'(m); cfg_last = L'(last); cfg_rep = rep;
        step("R7", 0, 100);
        cfg_we = 1'b0;
    endtask

    task automatic restart();
        sym_rst = 1'b1;
        step("R10", 0, 100);
        sym_rst = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) tab[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, idle input
        @(negedge clk); m_ready = 1'b1; #1;
        chk("R1", "m_valid idle", m_valid, 0);
        chk("R1", "m_last idle", m_last, 0);
        for (int i = 0; i < 6; i++) step("R1", 100, 100);   // N=2, no prefix

        // R4 R5 R11: schedule 3,0,5,1 repeating, N=4
        wr_tab(0, 3); wr_tab(1, 0); wr_tab(2, 5); wr_tab(3, 1);
        wr_cfg(2, 3, 1'b1);
        restart();
        for (int i = 0; i < 80; i++) step("R4", 100, 100);
        for (int i = 0; i < 40; i++) step("R5", 100, 100);
        chk("R11", "entry 0 stored", tab[1], 0);

        // R9 R2: random valid/ready
        for (int i = 0; i < 400; i++) step("R9", 65, 55);

        // R8: writes arriving mid-window
        for (int i = 0; i < 400; i++) begin
            if (i % 13 == 5) begin
                tab_we = 1'b1; tab_idx = L'($urandom_range(3)); tab_cp = CPW'($urandom_range(6));
            end
            if (i % 37 == 11) begin
                cfg_we = 1'b1; cfg_log2n = MW'($urandom_range(1, 3)); cfg_last = L'(3); cfg_rep = 1'b1;
            end
            step("R8", 80, 70);
            tab_we = 1'b0; cfg_we = 1'b0;
        end

        // R6: run-once list of two entries
        wr_tab(0, 4); wr_tab(1, 2);
        wr_cfg(2, 1, 1'b0);
        restart();
        for (int i = 0; i < 60; i++) step("R6", 100, 100);
        for (int i = 0; i < 60; i++) step("R6", 70, 80);

        // R7: largest and smallest window, clamping
        wr_tab(0, 7);
        wr_cfg(15, 0, 1'b1);              // clamps to MAXL
        restart();
        for (int i = 0; i < 2100; i++) step("R7", 100, 100);
        wr_cfg(0, 0, 1'b1);               // clamps to 1
        for (int i = 0; i < 40; i++) step("R7", 100, 100);

        // R10: restarts mid-window
        wr_tab(0, 3); wr_tab(1, 1);
        wr_cfg(3, 1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 7 + 3 * k; i++) step("R10", 90, 90);
            restart();
        end
        for (int i = 0; i < 60; i++) step("R10", 90, 90);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule